// File: doc/BRIEF.md
# Sequential Prefetch Trigger Controller

This block decides when a flash read controller should speculatively fetch the line that follows a demand read. Every accepted demand read is qualified by the master that issued it, by its kind (instruction or data), by the global buffer enable, by a prefetch limit field and by whether the read hit a page buffer. A qualified read arms a pending trigger. The trigger holds the index of the next line: the read address rounded up to the next line boundary.

On the first idle bus cycle after the trigger, the block presents the pending line index on a lookup port. The buffer lookup answers in the same cycle whether that line is already resident. If it is not, the block raises a registered prefetch request carrying the line index. The request stays high until the fill logic returns a completion pulse. Only one prefetch is in flight at a time. A newer demand read always replaces a pending trigger, and a line index that would wrap past the top of the address range is never requested.

Top module: `seqpf_trigger`

## Requirements
- R1: While reset is high, and in the cycle after it, `pf_req_o` and `lookup_valid_o` are low.
- R2: A read from a master whose bit in `cfg_master_en_i` is 0 never triggers a prefetch. A read from a master whose bit is 1 may trigger one.
- R3: An instruction read (`rd_instr_i`=1) triggers only when `cfg_instr_pf_en_i`=1. A data read (`rd_instr_i`=0) triggers only when `cfg_data_pf_en_i`=1.
- R4: No prefetch is triggered while `cfg_buf_en_i`=0 or while `cfg_pf_limit_i`=0.
- R5: With `cfg_pf_limit_i`=1, only a read that missed (`rd_hit_i`=0) may trigger. With `cfg_pf_limit_i` of 2 or more, a read that hit may trigger as well.
- R6: The requested line index `pf_line_o` equals `rd_addr_i[ADDR_W-1:4]` + 1, for a line size of 16 bytes.
- R7: When the read lies in the last line of the address range, no prefetch is requested.
- R8: A pending line that `lookup_resident_i` reports as resident in the idle cycle is not requested, and the trigger is consumed.
- R9: The prefetch request rises in the clock cycle that follows the first idle cycle after the triggering read. An idle cycle is one with `bus_idle_i`=1 and `rd_valid_i`=0. No request is raised while the bus stays busy.
- R10: A demand read that arrives while a trigger is pending replaces it. If the new read is not qualified, the pending trigger is dropped.
- R11: `pf_req_o` and `pf_line_o` hold until `pf_done_i` is sampled high, and `pf_req_o` falls in the following cycle. A trigger that becomes pending while a request is outstanding waits, and launches on the first idle cycle after the request has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid_i | input | 1 | Demand read accepted this cycle |
| rd_addr_i | input | ADDR_W | Byte address of the demand read |
| rd_master_i | input | MID_W | Issuing master number |
| rd_instr_i | input | 1 | 1 = instruction fetch, 0 = data read |
| rd_hit_i | input | 1 | Demand read was served from a page buffer |
| bus_idle_i | input | 1 | No bus transfer this cycle |
| cfg_buf_en_i | input | 1 | Global buffer enable |
| cfg_pf_limit_i | input | LIMIT_W | Prefetch limit, 0 disables |
| cfg_instr_pf_en_i | input | 1 | Instruction prefetch enable |
| cfg_data_pf_en_i | input | 1 | Data prefetch enable |
| cfg_master_en_i | input | NUM_MASTERS | Per-master trigger enable |
| lookup_line_o | output | LINE_W | Line index being checked for residency |
| lookup_valid_o | output | 1 | A trigger is pending |
| lookup_resident_i | input | 1 | Same-cycle answer: line already buffered |
| pf_req_o | output | 1 | Prefetch request, held until done |
| pf_line_o | output | LINE_W | Line index to prefetch |
| pf_done_i | input | 1 | Fill of the outstanding prefetch finished |

## Verification
The bench builds the block with its default parameters: a 24-bit byte address, 16-byte lines and four masters. With these values the 20-bit line index is small enough for the bench to place reads in the very last line, which brings the no-wrap rule within reach. The four-bit master mask lets one master be blocked while its neighbours stay enabled. The 3-bit limit field covers the disabled value, the miss-only value and values well above 2.

// File: rtl/seqpf_pkg.sv
package seqpf_pkg;

  typedef enum logic {
    ACC_DATA  = 1'b0,
    ACC_INSTR = 1'b1
  } acc_kind_e;

  // limit thresholds: 1 = after misses only, 2 and above = after hits as well
  localparam int unsigned LIM_MISS_ONLY = 1;
  localparam int unsigned LIM_HIT_ALSO  = 2;

endpackage

// File: rtl/seqpf_qualify.sv
module seqpf_qualify
  import seqpf_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 4,
  parameter int unsigned MID_W       = 2,
  parameter int unsigned LIMIT_W     = 3
) (
  input  logic                   buf_en_i,
  input  logic [LIMIT_W-1:0]     limit_i,
  input  logic                   instr_en_i,
  input  logic                   data_en_i,
  input  logic [NUM_MASTERS-1:0] master_en_i,
  input  logic [MID_W-1:0]       master_i,
  input  logic                   instr_i,
  input  logic                   hit_i,
  output logic                   ok_o
);

  logic [NUM_MASTERS-1:0] master_sel;
  logic                   master_ok;
  logic                   kind_ok;
  logic                   limit_ok;
  acc_kind_e              kind;

  // one-hot decode of the issuing master
  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_msel
    assign master_sel[g] = (int'(master_i) == g);
  end

  assign master_ok = |(master_sel & master_en_i);
  assign kind      = acc_kind_e'(instr_i);

  always_comb begin
    unique case (kind)
      ACC_INSTR: kind_ok = instr_en_i;
      default:   kind_ok = data_en_i;
    endcase
  end

  always_comb begin
    if (int'(limit_i) == 0)
      limit_ok = 1'b0;
    else if (int'(limit_i) >= int'(LIM_HIT_ALSO))
      limit_ok = 1'b1;
    else
      limit_ok = !hit_i;
  end

  assign ok_o = buf_en_i && limit_ok && kind_ok && master_ok;

endmodule

// File: rtl/seqpf_nextline.sv
module seqpf_nextline #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned LINE_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [LINE_W-1:0] next_line_o,
  output logic              at_top_o
);

  logic [LINE_W-1:0] cur_line;

  assign cur_line    = addr_i[ADDR_W-1:OFF_W];
  assign at_top_o    = &cur_line;
  assign next_line_o = cur_line + LINE_W'(1);

endmodule

// File: rtl/seqpf_issue.sv
module seqpf_issue #(
  parameter int unsigned LINE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_seen_i,
  input  logic              trig_ok_i,
  input  logic [LINE_W-1:0] trig_line_i,
  input  logic              idle_i,
  input  logic              resident_i,
  input  logic              done_i,
  output logic [LINE_W-1:0] lookup_line_o,
  output logic              lookup_valid_o,
  output logic              pf_req_o,
  output logic [LINE_W-1:0] pf_line_o
);

  logic              pend_q;
  logic [LINE_W-1:0] pend_line_q;
  logic              req_q;
  logic [LINE_W-1:0] line_q;
  logic              launch_slot;

  // a pending trigger may act only when no request is outstanding
  assign launch_slot = pend_q && idle_i && !req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_line_q <= '0;
      req_q       <= 1'b0;
      line_q      <= '0;
    end else begin
      if (req_q && done_i)
        req_q <= 1'b0;
      if (trig_seen_i) begin
        pend_q <= trig_ok_i;
        if (trig_ok_i)
          pend_line_q <= trig_line_i;
      end else if (launch_slot) begin
        pend_q <= 1'b0;
        if (!resident_i) begin
          req_q  <= 1'b1;
          line_q <= pend_line_q;
        end
      end
    end
  end

  assign lookup_line_o  = pend_line_q;
  assign lookup_valid_o = pend_q;
  assign pf_req_o       = req_q;
  assign pf_line_o      = line_q;

endmodule

// File: rtl/seqpf_trigger.sv
module seqpf_trigger #(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned LINE_BYTES  = 16,
  parameter int unsigned NUM_MASTERS = 4,
  parameter int unsigned LIMIT_W     = 3,
  localparam int unsigned OFF_W      = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W     = ADDR_W - OFF_W,
  localparam int unsigned MID_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_valid_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  logic [MID_W-1:0]       rd_master_i,
  input  logic                   rd_instr_i,
  input  logic                   rd_hit_i,
  input  logic                   bus_idle_i,
  input  logic                   cfg_buf_en_i,
  input  logic [LIMIT_W-1:0]     cfg_pf_limit_i,
  input  logic                   cfg_instr_pf_en_i,
  input  logic                   cfg_data_pf_en_i,
  input  logic [NUM_MASTERS-1:0] cfg_master_en_i,
  output logic [LINE_W-1:0]      lookup_line_o,
  output logic                   lookup_valid_o,
  input  logic                   lookup_resident_i,
  output logic                   pf_req_o,
  output logic [LINE_W-1:0]      pf_line_o,
  input  logic                   pf_done_i
);

  logic              qual_ok;
  logic              at_top;
  logic [LINE_W-1:0] next_line;
  logic              idle_cycle;

  seqpf_qualify #(
    .NUM_MASTERS(NUM_MASTERS),
    .MID_W      (MID_W),
    .LIMIT_W    (LIMIT_W)
  ) u_qual (
    .buf_en_i   (cfg_buf_en_i),
    .limit_i    (cfg_pf_limit_i),
    .instr_en_i (cfg_instr_pf_en_i),
    .data_en_i  (cfg_data_pf_en_i),
    .master_en_i(cfg_master_en_i),
    .master_i   (rd_master_i),
    .instr_i    (rd_instr_i),
    .hit_i      (rd_hit_i),
    .ok_o       (qual_ok)
  );

  seqpf_nextline #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .LINE_W(LINE_W)
  ) u_next (
    .addr_i     (rd_addr_i),
    .next_line_o(next_line),
    .at_top_o   (at_top)
  );

  assign idle_cycle = bus_idle_i && !rd_valid_i;

  seqpf_issue #(
    .LINE_W(LINE_W)
  ) u_issue (
    .clk           (clk),
    .rst           (rst),
    .trig_seen_i   (rd_valid_i),
    .trig_ok_i     (qual_ok && !at_top),
    .trig_line_i   (next_line),
    .idle_i        (idle_cycle),
    .resident_i    (lookup_resident_i),
    .done_i        (pf_done_i),
    .lookup_line_o (lookup_line_o),
    .lookup_valid_o(lookup_valid_o),
    .pf_req_o      (pf_req_o),
    .pf_line_o     (pf_line_o)
  );

endmodule

// File: rtl/seqpf_trigger_chk.sv
module seqpf_trigger_chk #(
  parameter int unsigned LINE_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_valid_i,
  input logic              bus_idle_i,
  input logic              lookup_resident_i,
  input logic              pf_req_o,
  input logic [LINE_W-1:0] pf_line_o,
  input logic              pf_done_i
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !pf_req_o);

  // R11
  hold_until_done_chk: assert property (@(posedge clk) disable iff (rst)
    (pf_req_o && !pf_done_i) |=> (pf_req_o && $stable(pf_line_o)));

  // R11
  drop_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (pf_req_o && pf_done_i) |=> !pf_req_o);

  // R9
  launch_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pf_req_o) |-> $past(bus_idle_i && !rd_valid_i));

  // R8
  not_resident_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pf_req_o) |-> $past(!lookup_resident_i));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    pf_req_o |-> (pf_line_o != '0));

endmodule

bind seqpf_trigger seqpf_trigger_chk #(.LINE_W(LINE_W)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .rd_valid_i       (rd_valid_i),
  .bus_idle_i       (bus_idle_i),
  .lookup_resident_i(lookup_resident_i),
  .pf_req_o         (pf_req_o),
  .pf_line_o        (pf_line_o),
  .pf_done_i        (pf_done_i)
);

// File: tb/seqpf_trigger_tb_top.sv
module seqpf_trigger_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_valid = 1'b0;
  logic [23:0] rd_addr = '0;
  logic [1:0]  rd_master = '0;
  logic        rd_instr = 1'b0;
  logic        rd_hit = 1'b0;
  logic        bus_idle = 1'b0;
  logic        buf_en = 1'b1;
  logic [2:0]  limit = 3'd2;
  logic        ipfe = 1'b1;
  logic        dpfe = 1'b1;
  logic [3:0]  men = 4'b1111;
  logic [19:0] lookup_line;
  logic        lookup_valid;
  logic        resident;
  logic        pf_req;
  logic [19:0] pf_line;
  logic        pf_done = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";

  logic [19:0] res_tab [4];
  bit          res_use [4];

  always_comb begin
    resident = 1'b0;
    for (int i = 0; i < 4; i++)
      if (res_use[i] && res_tab[i] == lookup_line) resident = 1'b1;
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  seqpf_trigger dut_i (
    .clk(clk), .rst(rst),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_master_i(rd_master),
    .rd_instr_i(rd_instr), .rd_hit_i(rd_hit), .bus_idle_i(bus_idle),
    .cfg_buf_en_i(buf_en), .cfg_pf_limit_i(limit),
    .cfg_instr_pf_en_i(ipfe), .cfg_data_pf_en_i(dpfe),
    .cfg_master_en_i(men),
    .lookup_line_o(lookup_line), .lookup_valid_o(lookup_valid),
    .lookup_resident_i(resident),
    .pf_req_o(pf_req), .pf_line_o(pf_line), .pf_done_i(pf_done)
  );

  // behavioural reference
  bit      m_pend = 0;
  int      m_pline = 0;
  bit      m_req = 0;
  int      m_line = 0;

  function automatic bit model_res(int line);
    for (int i = 0; i < 4; i++)
      if (res_use[i] && int'(res_tab[i]) == line) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pend = 0; m_req = 0; m_line = 0; m_pline = 0;
    end else begin
      bit nreq;
      nreq = m_req;
      if (m_req && pf_done) nreq = 0;
      if (rd_valid) begin
        int idx;
        bit ok;
        idx = int'(rd_addr) / 16;
        ok = buf_en && (limit != 0) && men[rd_master]
             && (rd_instr ? ipfe : dpfe)
             && (!rd_hit || limit >= 2)
             && (idx != 20'hFFFFF);
        m_pend = ok;
        if (ok) m_pline = idx + 1;
      end else if (m_pend && bus_idle && !m_req) begin
        m_pend = 0;
        if (!model_res(m_pline)) begin
          nreq = 1;
          m_line = m_pline;
        end
      end
      m_req = nreq;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the reference
  always @(negedge clk) begin
    if (!rst) begin
      check({cur_req, " model pf_req"}, int'(pf_req), int'(m_req));
      if (m_req) check({cur_req, " model pf_line"}, int'(pf_line), m_line);
      check({cur_req, " model lookup_valid"}, int'(lookup_valid), int'(m_pend));
    end
  end

  task automatic drive(bit v, logic [23:0] a, logic [1:0] m, bit ins, bit hit,
                       bit idle, bit done);
    rd_valid = v; rd_addr = a; rd_master = m; rd_instr = ins; rd_hit = hit;
    bus_idle = idle; pf_done = done;
    @(negedge clk);
  endtask

  task automatic rd(logic [23:0] a, logic [1:0] m, bit ins, bit hit);
    drive(1, a, m, ins, hit, 0, 0);
  endtask

  task automatic idle(bit done);
    drive(0, '0, 0, 0, 0, 1, done);
  endtask

  task automatic busy();
    drive(0, '0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_pf();
    idle(1);
    idle(0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin res_use[i] = 0; res_tab[i] = '0; end
    @(negedge clk);
    check("R1 pf_req in reset", int'(pf_req), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 pf_req after reset", int'(pf_req), 0);
    check("R1 lookup_valid after reset", int'(lookup_valid), 0);

    cur_req = "R6";
    rd(24'h001234, 0, 1, 0);
    check("R9 no request before idle", int'(pf_req), 0);
    idle(0);
    check("R6 request raised", int'(pf_req), 1);
    check("R6 next line index", int'(pf_line), 'h124);
    finish_pf();

    cur_req = "R9";
    rd(24'h002340, 1, 0, 0);
    busy(); busy();
    check("R9 held while bus busy", int'(pf_req), 0);
    idle(0);
    check("R9 launch after first idle", int'(pf_req), 1);
    finish_pf();

    cur_req = "R2";
    men = 4'b1101;
    rd(24'h004000, 1, 1, 0); idle(0);
    check("R2 blocked master", int'(pf_req), 0);
    rd(24'h004000, 2, 1, 0); idle(0);
    check("R2 enabled master", int'(pf_req), 1);
    finish_pf();
    men = 4'b1111;

    cur_req = "R3";
    ipfe = 0;
    rd(24'h005000, 0, 1, 0); idle(0);
    check("R3 instr disabled", int'(pf_req), 0);
    rd(24'h005000, 0, 0, 0); idle(0);
    check("R3 data enabled", int'(pf_req), 1);
    finish_pf();
    ipfe = 1; dpfe = 0;
    rd(24'h005100, 0, 0, 0); idle(0);
    check("R3 data disabled", int'(pf_req), 0);
    dpfe = 1;

    cur_req = "R4";
    buf_en = 0;
    rd(24'h006000, 0, 1, 0); idle(0);
    check("R4 buffer enable off", int'(pf_req), 0);
    buf_en = 1; limit = 0;
    rd(24'h006000, 0, 1, 0); idle(0);
    check("R4 limit zero", int'(pf_req), 0);

    cur_req = "R5";
    limit = 1;
    rd(24'h007000, 3, 1, 1); idle(0);
    check("R5 limit1 after hit", int'(pf_req), 0);
    rd(24'h007000, 3, 1, 0); idle(0);
    check("R5 limit1 after miss", int'(pf_req), 1);
    finish_pf();
    limit = 2;
    rd(24'h007100, 3, 1, 1); idle(0);
    check("R5 limit2 after hit", int'(pf_req), 1);
    finish_pf();
    limit = 7;
    rd(24'h007200, 3, 0, 1); idle(0);
    check("R5 limit7 after hit", int'(pf_req), 1);
    check("R5 line", int'(pf_line), 'h721);
    finish_pf();
    limit = 2;

    cur_req = "R7";
    rd(24'hFFFFF8, 0, 1, 0); idle(0);
    check("R7 top line no prefetch", int'(pf_req), 0);
    rd(24'hFFFFE8, 0, 1, 0); idle(0);
    check("R7 line below top", int'(pf_req), 1);
    check("R7 line below top index", int'(pf_line), 'hFFFFF);
    finish_pf();

    cur_req = "R8";
    res_tab[0] = 20'h00201; res_use[0] = 1;
    rd(24'h002000, 0, 1, 0); idle(0);
    check("R8 resident skipped", int'(pf_req), 0);
    check("R8 trigger consumed", int'(lookup_valid), 0);
    idle(0);
    check("R8 no late request", int'(pf_req), 0);
    res_use[0] = 0;

    cur_req = "R10";
    rd(24'h003000, 0, 1, 0);
    rd(24'h005010, 0, 1, 0); idle(0);
    check("R10 newer read wins", int'(pf_req), 1);
    check("R10 newer line", int'(pf_line), 'h502);
    finish_pf();
    men = 4'b1110;
    rd(24'h003000, 1, 1, 0);
    rd(24'h003000, 0, 1, 0); idle(0);
    check("R10 unqualified read drops trigger", int'(pf_req), 0);
    men = 4'b1111;

    cur_req = "R11";
    rd(24'h008000, 0, 1, 0); idle(0);
    rd(24'h009000, 0, 1, 0); idle(0); idle(0);
    check("R11 still outstanding", int'(pf_req), 1);
    check("R11 line held", int'(pf_line), 'h801);
    check("R11 newer trigger waits", int'(lookup_valid), 1);
    idle(1);
    check("R11 cleared after done", int'(pf_req), 0);
    idle(0);
    check("R11 waiting trigger launches", int'(pf_req), 1);
    check("R11 waiting line", int'(pf_line), 'h901);
    finish_pf();

    repeat (3) idle(0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule